// File: doc/BRIEF.md
# Serial Peripheral Master with Word Queues

This block is a serial peripheral master. The host places words into a transmit queue and takes words from a receive queue. The engine drives a serial clock, an active-low select line and a data-out line, and samples a data-in line. It moves each queued word out as one frame, most significant bit first. Each frame is 4 to 16 bits long, and the length is programmable. The clock polarity and phase are selectable, and the rate comes from a programmable divider of the system clock.

A transfer mode picks one of three uses of the link. In exchange mode, each frame pops a transmit word and pushes the word received with it. In send-only mode, the bits received are shifted in but then thrown away. In fetch-only mode, zeros are sent, and the host sets how many frames to run by writing a frame count. Both queues are 8 entries of 16 bits, with one frame per entry, right-aligned.

Back-pressure on the host side: a word on `tx_data` is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low whenever the transmit queue is full. `rx_valid` is high whenever the receive queue holds a word, and `rx_data` shows the oldest word. That word is removed on a clock edge where `rx_valid` and `rx_ready` are both high. The serial side has no back-pressure. A received frame that finds the receive queue full is dropped.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `cs_n` is 1, `tx_empty` and `rx_empty` are 1, `tx_full`, `rx_full`, `rx_valid` and `rx_overflow` are 0, and `tx_ready` is 1.
- R2: Whenever `cs_n` is 1, `sck` equals `cfg_cpol`.
- R3: Data is sampled on the `sck` rising edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise. Data changes on the opposite edge. With `cfg_cpha`=1, `mosi` gets its first bit at the first `sck` edge. With `cfg_cpha`=0, `mosi` holds the first bit when `cs_n` falls. All four combinations exchange data correctly.
- R4: A frame is L = `cfg_len_m1`+1 bits long, for L from 4 to 16, and is sent MSB first. Only bits L-1..0 of a transmit entry are sent. A received frame is stored right-aligned, with the bits above L-1 set to zero.
- R5: Each half period of `sck` lasts `cfg_div` system clocks. A value of 0 acts as 1. The first edge comes `cfg_div` clocks after `cs_n` falls.
- R6: `cs_n` stays low between back-to-back frames and rises only when no further frame is pending. Each frame gives exactly 2L `sck` edges.
- R7: `cfg_tmode`=0 (or 3) is exchange mode: each frame pops one transmit entry, and the received frame is pushed to the receive queue at the end of the frame.
- R8: `cfg_tmode`=1 is send-only mode: transmit entries are sent, and the receive queue is never written.
- R9: `cfg_tmode`=2 is fetch-only mode: a pulse on `frm_cnt_wr` loads `frm_cnt` frames to run. `mosi` stays 0, each received frame is pushed, and the transmit queue is left untouched.
- R10: The transmit queue holds 8 entries. When it is full, `tx_full`=1 and `tx_ready`=0, and any further pushes are ignored.
- R11: A frame received while the receive queue is full is dropped, and `rx_overflow` is set. `rx_overflow` stays set until reset.
- R12: `rx_valid` is high exactly when the receive queue is not empty. Entries come out in arrival order, one per accepted `rx_ready` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 1: the first `sck` edge shifts data out |
| cfg_len_m1 | input | 4 | Frame length minus one (3..15) |
| cfg_div | input | 8 | Half period of `sck` in system clocks |
| cfg_tmode | input | 2 | 0/3 exchange, 1 send-only, 2 fetch-only |
| frm_cnt_wr | input | 1 | Pulse that loads the fetch-only frame count |
| frm_cnt | input | 8 | Number of frames for fetch-only mode |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit queue can accept a word |
| tx_data | input | 16 | Transmit word, right-aligned |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Host takes the receive word |
| rx_data | output | 16 | Oldest received word, right-aligned |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_empty | output | 1 | Transmit queue empty (interrupt flag) |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full (interrupt flag) |
| rx_overflow | output | 1 | Sticky flag for a dropped received frame |
| busy | output | 1 | A frame sequence is in progress |

## Verification
The select line falls on the clock edge after work becomes available. The first `sck` edge follows `cfg_div` clocks later, and each later edge follows after another `cfg_div` clocks. A received word enters the receive queue on the same edge as the last `sck` edge of its frame, so `rx_valid` is seen one clock later. The bench measures the time from the select fall to the first edge, and between the first two edges, against `cfg_div` clock periods. It reads the queues only after `busy` has dropped, and it samples all host-side outputs on the falling system clock edge. A serial slave model in the bench follows the required edge rules, so that data errors in any mode show up as mismatched words.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    TM_XCHG     = 2'd0,
    TM_SENDONLY = 2'd1,
    TM_FETCH    = 2'd2,
    TM_XCHG_ALT = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_st_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half_div,
  output logic          tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = (half_div == '0) ? '0 : half_div - 1'b1;
  assign tick = en && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [LW-1:0] len_m1,
  input  logic [1:0]    tmode,
  input  logic          tick,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_word,
  input  logic          frames_left_nz,
  input  logic          miso,
  output logic          tx_pop,
  output logic          frame_dec,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          run,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi
);
  eng_st_e       st;
  tmode_e        md;
  logic [LW:0]   edge_k;
  logic          ph, cs_q, mosi_q;
  logic [DW-1:0] tx_sh, rx_sh, aligned, rx_next;
  logic          fetch, keep_rx, work, leading, last, samp, drv, load;

  always_comb begin
    md      = tmode_e'(tmode);
    fetch   = (md == TM_FETCH);
    keep_rx = (md != TM_SENDONLY);
    work    = fetch ? frames_left_nz : tx_avail;
    leading = ~edge_k[0];
    last    = (edge_k == {len_m1, 1'b1});
    samp    = leading ^ cpha;
    drv     = cpha ? leading : (~leading & ~last);
    load    = work && ((st == ST_IDLE) || (st == ST_GAP && tick));
    aligned = fetch ? '0 : (tx_word << (LW'(DW-1) - len_m1));
    rx_next = samp ? {rx_sh[DW-2:0], miso} : rx_sh;
  end

  assign tx_pop    = load && !fetch;
  assign frame_dec = load && fetch;
  assign rx_push   = (st == ST_SHIFT) && tick && last && keep_rx;
  assign rx_word   = rx_next;
  assign run       = (st != ST_IDLE);
  assign sck       = cpol ^ ph;
  assign cs_n      = cs_q;
  assign mosi      = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      edge_k <= '0;
      ph     <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (load) begin
      st     <= ST_SHIFT;
      cs_q   <= 1'b0;
      edge_k <= '0;
      ph     <= 1'b0;
      rx_sh  <= '0;
      mosi_q <= cpha ? 1'b0 : aligned[DW-1];
      tx_sh  <= cpha ? aligned : (aligned << 1);
    end else begin
      case (st)
        ST_SHIFT: if (tick) begin
          ph <= ~ph;
          if (samp) rx_sh <= rx_next;
          if (drv) begin
            mosi_q <= tx_sh[DW-1];
            tx_sh  <= tx_sh << 1;
          end
          if (last) st <= ST_GAP;
          else      edge_k <= edge_k + 1'b1;
        end
        ST_GAP: if (tick) begin
          st     <= ST_IDLE;
          cs_q   <= 1'b1;
          mosi_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8,
  parameter int CNTW  = 8,
  parameter int LW    = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [LW-1:0]   cfg_len_m1,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [1:0]      cfg_tmode,
  input  logic            frm_cnt_wr,
  input  logic [CNTW-1:0] frm_cnt,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [DW-1:0]   tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            sck,
  output logic            cs_n,
  output logic            mosi,
  input  logic            miso,
  output logic            tx_empty,
  output logic            tx_full,
  output logic            rx_empty,
  output logic            rx_full,
  output logic            rx_overflow,
  output logic            busy
);
  logic            tick, run, tx_pop, frame_dec, rx_push;
  logic [DW-1:0]   tx_head, rx_word;
  logic [CNTW-1:0] frames_left;
  logic            ovf_q;

  spi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_valid), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rx_push), .wr_data(rx_word),
    .rd_en(rx_ready), .rd_data(rx_data),
    .full(rx_full), .empty(rx_empty)
  );

  spi_clkdiv #(.CW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(run), .half_div(cfg_div), .tick(tick)
  );

  spi_engine #(.DW(DW), .LW(LW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .len_m1(cfg_len_m1), .tmode(cfg_tmode),
    .tick(tick), .tx_avail(!tx_empty), .tx_word(tx_head),
    .frames_left_nz(frames_left != '0), .miso(miso),
    .tx_pop(tx_pop), .frame_dec(frame_dec), .rx_push(rx_push), .rx_word(rx_word),
    .run(run), .sck(sck), .cs_n(cs_n), .mosi(mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_left <= '0;
      ovf_q       <= 1'b0;
    end else begin
      if (frm_cnt_wr)     frames_left <= frm_cnt;
      else if (frame_dec) frames_left <= frames_left - 1'b1;
      if (rx_push && rx_full) ovf_q <= 1'b1;
    end
  end

  assign tx_ready    = !tx_full;
  assign rx_valid    = !rx_empty;
  assign rx_overflow = ovf_q;
  assign busy        = run;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic [1:0] cfg_tmode,
  input logic       cs_n,
  input logic       sck,
  input logic       tx_full,
  input logic       tx_ready,
  input logic       rx_empty,
  input logic       rx_valid,
  input logic       rx_overflow
);
  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cfg_cpol)); // R2
  AST_NO_TX_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_ready); // R10
  AST_RX_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_valid); // R12
  AST_SENDONLY_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tmode == 2'd1 && rx_empty) |=> rx_empty); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow); // R11
endmodule

bind spi_fifo_master spi_fifo_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_tmode(cfg_tmode),
  .cs_n(cs_n), .sck(sck), .tx_full(tx_full), .tx_ready(tx_ready),
  .rx_empty(rx_empty), .rx_valid(rx_valid), .rx_overflow(rx_overflow)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  logic clk = 0, rst_n = 0;
  logic cfg_cpol = 0, cfg_cpha = 0;
  logic [3:0] cfg_len_m1 = 4'd7;
  logic [7:0] cfg_div = 8'd2;
  logic [1:0] cfg_tmode = 2'd2;
  logic frm_cnt_wr = 0;
  logic [7:0] frm_cnt = 0;
  logic tx_valid = 0, tx_ready;
  logic [15:0] tx_data = 0;
  logic rx_valid, rx_ready = 0;
  logic [15:0] rx_data;
  logic sck, cs_n, mosi, miso = 0;
  logic tx_empty, tx_full, rx_empty, rx_full, rx_overflow, busy;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  spi_fifo_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_len_m1(cfg_len_m1), .cfg_div(cfg_div), .cfg_tmode(cfg_tmode),
    .frm_cnt_wr(frm_cnt_wr), .frm_cnt(frm_cnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_overflow(rx_overflow), .busy(busy)
  );

  function automatic logic [15:0] txw(int k);
    return 16'hA5C3 ^ (16'(k) * 16'h1357);
  endfunction
  function automatic logic [15:0] slw(int k);
    return 16'h3C96 + 16'(k) * 16'h0F1D;
  endfunction
  function automatic logic [15:0] msk(int len);
    return 16'((17'h1 << len) - 1);
  endfunction

  // serial slave model
  logic [15:0] sl_cur, sl_rx;
  int sl_out, sl_bits, sl_k, got_n, sck_edges, cs_falls;
  logic [15:0] got [32];
  realtime t_fall, t_e1, t_e2;

  task automatic present(int len);
    if (sl_out == len) begin
      sl_cur = slw(sl_k); sl_k++; sl_out = 0;
    end
    miso = sl_cur[len-1-sl_out];
    sl_out++;
  endtask

  always @(negedge cs_n) begin
    cs_falls++;
    t_fall = $realtime;
    sl_cur = slw(sl_k); sl_k++; sl_out = 0; sl_bits = 0; sl_rx = 0;
    if (!cfg_cpha) present(int'(cfg_len_m1) + 1);
  end

  always @(sck) begin
    if (cs_n === 1'b0) begin
      int len;
      len = int'(cfg_len_m1) + 1;
      sck_edges++;
      if (sck_edges == 1) t_e1 = $realtime;
      if (sck_edges == 2) t_e2 = $realtime;
      if ((sck == 1'b1) == (cfg_cpol == cfg_cpha)) begin
        sl_rx = {sl_rx[14:0], mosi};
        sl_bits++;
        if (sl_bits == len) begin
          if (got_n < 32) got[got_n] = sl_rx;
          got_n++; sl_bits = 0; sl_rx = 0;
        end
      end else begin
        present(len);
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_model();
    sl_k = 0; got_n = 0; sck_edges = 0; cs_falls = 0; sl_out = 0; sl_bits = 0;
  endtask

  task automatic push(logic [15:0] w);
    @(negedge clk); tx_valid = 1; tx_data = w;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic pop_expect(logic [15:0] exp, string req);
    @(negedge clk);
    chk(rx_valid == 1'b1, req, 32'(rx_valid), 32'd1);
    chk(rx_data == exp, req, 32'(rx_data), 32'(exp));
    rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic wait_idle();
    int i;
    repeat (3) @(negedge clk);
    for (i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R6 idle", 32'(busy), 32'd0);
  endtask

  // generic burst: n words in given mode, all data checks
  task automatic burst(bit pol, bit pha, int len, int div, int n, string req);
    cfg_tmode = 2'd2; cfg_cpol = pol; cfg_cpha = pha;
    cfg_len_m1 = 4'(len - 1); cfg_div = 8'(div);
    clr_model();
    for (int i = 0; i < n; i++) push(txw(i));
    @(negedge clk); cfg_tmode = 2'd0;
    wait_idle();
    cfg_tmode = 2'd2;
    chk(got_n == n, req, 32'(got_n), 32'(n));
    for (int i = 0; i < n; i++)
      chk(got[i] == (txw(i) & msk(len)), {req, " R4 mosi"}, 32'(got[i]), 32'(txw(i) & msk(len)));
    for (int i = 0; i < n; i++) pop_expect(slw(i) & msk(len), {req, " R7 rx"});
    chk(cs_falls == 1, "R6 one select", 32'(cs_falls), 32'd1);
    chk(sck_edges == 2*len*n, "R6 edges", 32'(sck_edges), 32'(2*len*n));
    chk(rx_empty, "R12 drained", 32'(rx_empty), 32'd1);
  endtask

  task automatic t_reset();
    chk(cs_n == 1 && tx_empty && rx_empty, "R1 cs/empty", {29'd0, cs_n, tx_empty, rx_empty}, 32'd7);
    chk(!tx_full && !rx_full && !rx_valid && !rx_overflow && tx_ready, "R1 flags",
        {27'd0, tx_full, rx_full, rx_valid, rx_overflow, tx_ready}, 32'd1);
  endtask

  task automatic t_idle_level();
    @(negedge clk); cfg_cpol = 1;
    @(negedge clk);
    chk(sck == 1'b1, "R2 idle high", 32'(sck), 32'd1);
    cfg_cpol = 0;
    @(negedge clk);
    chk(sck == 1'b0, "R2 idle low", 32'(sck), 32'd0);
  endtask

  task automatic t_timing();
    burst(0, 0, 8, 3, 2, "R3 mode0");
    chk(t_e1 - t_fall == 24.0, "R5 first edge", 32'(int'(t_e1 - t_fall)), 32'd24);
    chk(t_e2 - t_e1 == 24.0, "R5 half period", 32'(int'(t_e2 - t_e1)), 32'd24);
  endtask

  task automatic t_sendonly();
    cfg_tmode = 2'd2; cfg_cpol = 0; cfg_cpha = 1; cfg_len_m1 = 4'd9; cfg_div = 8'd1;
    clr_model();
    push(txw(3)); push(txw(4));
    @(negedge clk); cfg_tmode = 2'd1;
    wait_idle();
    chk(got_n == 2 && got[1] == (txw(4) & msk(10)), "R8 sent",
        32'(got[1]), 32'(txw(4) & msk(10)));
    chk(rx_empty && !rx_valid, "R8 rx untouched", 32'(rx_valid), 32'd0);
    cfg_tmode = 2'd2;
  endtask

  task automatic t_fetch();
    cfg_tmode = 2'd2; cfg_cpol = 1; cfg_cpha = 1; cfg_len_m1 = 4'd7; cfg_div = 8'd2;
    clr_model();
    push(txw(9));
    @(negedge clk); frm_cnt = 8'd3; frm_cnt_wr = 1;
    @(negedge clk); frm_cnt_wr = 0;
    wait_idle();
    chk(got_n == 3, "R9 frames", 32'(got_n), 32'd3);
    for (int i = 0; i < 3; i++) chk(got[i] == 16'h0, "R9 mosi zero", 32'(got[i]), 32'd0);
    for (int i = 0; i < 3; i++) pop_expect(slw(i) & msk(8), "R9 rx");
    chk(!tx_empty, "R9 tx untouched", 32'(tx_empty), 32'd0);
    clr_model();
    @(negedge clk); cfg_tmode = 2'd1;
    wait_idle();
    cfg_tmode = 2'd2;
    chk(got_n == 1 && got[0] == (txw(9) & msk(8)), "R9 kept word",
        32'(got[0]), 32'(txw(9) & msk(8)));
  endtask

  task automatic t_full();
    cfg_tmode = 2'd2; cfg_cpol = 0; cfg_cpha = 0; cfg_len_m1 = 4'd5; cfg_div = 8'd1;
    clr_model();
    for (int i = 0; i < 9; i++) push(txw(20 + i));
    @(negedge clk);
    chk(tx_full && !tx_ready, "R10 full", {30'd0, tx_full, tx_ready}, 32'd2);
    cfg_tmode = 2'd0;
    wait_idle();
    cfg_tmode = 2'd2;
    chk(got_n == 8, "R10 ninth ignored", 32'(got_n), 32'd8);
    chk(got[7] == (txw(27) & msk(6)), "R10 last", 32'(got[7]), 32'(txw(27) & msk(6)));
    for (int i = 0; i < 8; i++) pop_expect(slw(i) & msk(6), "R7 full burst");
  endtask

  task automatic t_overflow();
    cfg_tmode = 2'd2; cfg_cpol = 0; cfg_cpha = 1; cfg_len_m1 = 4'd3; cfg_div = 8'd0;
    clr_model();
    chk(!rx_overflow, "R11 clear before", 32'(rx_overflow), 32'd0);
    @(negedge clk); frm_cnt = 8'd10; frm_cnt_wr = 1;
    @(negedge clk); frm_cnt_wr = 0;
    wait_idle();
    chk(rx_full && rx_overflow, "R11 set", {30'd0, rx_full, rx_overflow}, 32'd3);
    for (int i = 0; i < 8; i++) pop_expect(slw(i) & msk(4), "R11 first eight");
    @(negedge clk);
    chk(!rx_valid && rx_overflow, "R11 sticky", {30'd0, rx_valid, rx_overflow}, 32'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    clr_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_level();
    t_timing();
    burst(0, 1, 4, 2, 3, "R3 mode1");
    burst(1, 0, 12, 2, 2, "R3 mode2");
    burst(1, 1, 16, 1, 4, "R3 mode3");
    t_sendonly();
    t_fetch();
    t_full();
    t_overflow();
    finish_run();
  end
endmodule